// File: doc/BRIEF.md
# CPU Bus Cycle Length Timer

This block runs on the master clock and paces the CPU bus. Each bus cycle lasts 6, 8 or 12 master clocks. The length is fixed in the first clock of the cycle, from the address class of the access and a programmable fast-ROM bit. The block marks that first clock with `cyc_start` and the last clock with a one-clock `cyc_done` strobe. The clock after a strobe is the start of the next cycle. The CPU side holds the address and the internal-cycle flag steady during the start clock. The timer samples them on the edge that ends it.

Address decode splits the 24-bit address into an 8-bit bank and a 16-bit offset. It sorts each access into one of these classes:
- an internal operation with no memory access
- fast ROM
- slow ROM
- work RAM
- general I/O registers
- the two serial joypad port registers

The video timing block sends a one-clock refresh request. The timer then freezes for a fixed window of 40 master clocks, starting with the clock of the request. During that window no cycle advances, starts or ends.

Top module: `bus_cycle_timer`

## Requirements
- R1: In the first clock after reset is released, `cyc_start` is 1, `cyc_done` is 0 and `bus_stall` is 0; the fast-ROM bit resets to 0.
- R2: An access classed as ROM in a bank with bit 7 set (address 0x800000 and above) lasts 6 clocks when the fast-ROM bit is 1.
- R3: Any other ROM access lasts 8 clocks. ROM is any address not claimed by R4, R5 or R6, including banks 0x40–0x7D and 0xC0–0xFF, and offsets 0x6000 and up in banks whose bit 6 is clear.
- R4: Work RAM lasts 8 clocks. Work RAM is all of banks 0x7E and 0x7F, plus offsets below 0x2000 in every bank whose bit 6 is clear.
- R5: In banks whose bit 6 is clear, offsets 0x2000–0x5FFF are registers and last 6 clocks, except for the joypad ports.
- R6: Offsets 0x4016 and 0x4017 in banks whose bit 6 is clear are the joypad ports and last 12 clocks.
- R7: An access with `bus_internal` set lasts 6 clocks, whatever the address.
- R8: `cyc_done` is high for exactly the last non-stalled clock of a cycle, and the next clock is a start clock. Address and flag changes after the start clock do not change that cycle's length.
- R9: A `fast_we` pulse loads `fast_wdata` into the fast-ROM bit. The new value applies only to cycles that start after the write clock, even when the write happens in a start clock.
- R10: A refresh request raises `bus_stall` for exactly 40 consecutive clocks, starting with the request clock. While stalled, `cyc_done` and `cyc_start` are 0, the cycle position and length hold, and a cycle's non-stalled clock count is unchanged.
- R11: A refresh request made while a stall window is active is ignored and does not extend the window.
- R12: From the clock after the start clock until the next start clock, `cyc_len` shows the length of the cycle in progress: 6, 8 or 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Bus address: bank in [23:16], offset in [15:0] |
| bus_internal | input | 1 | Internal cycle with no memory access |
| fast_we | input | 1 | Write strobe for the fast-ROM bit |
| fast_wdata | input | 1 | Value loaded into the fast-ROM bit |
| refresh_req | input | 1 | One-clock request to begin a refresh stall window |
| cyc_start | output | 1 | Clock in which the next cycle's length is sampled |
| cyc_done | output | 1 | Last master clock of the current bus cycle |
| bus_stall | output | 1 | Refresh stall window is active |
| cyc_len | output | 4 | Length of the cycle in progress, in master clocks |

## Verification
The properties assume that the address and the internal flag are steady through the start clock. They also assume that refresh requests come only from a source that sends one-clock pulses. The driver changes the bus inputs only just after a rising edge that begins a start clock. It also scrambles the address mid-cycle on purpose, to show that the value sampled at the start is the one used. Refresh requests are single-clock pulses placed inside a cycle. A second pulse falls inside an open window, so a correct window still measures exactly 40 clocks.

// File: rtl/bct_pkg.sv
package bct_pkg;

    // Access class of one bus cycle
    typedef enum logic [2:0] {
        CLS_INTERNAL,
        CLS_ROM_FAST,
        CLS_ROM_SLOW,
        CLS_WRAM,
        CLS_REG,
        CLS_JOY
    } acc_class_e;

    localparam int BANK_W = 8;

endpackage

// File: rtl/bct_addr_decode.sv
module bct_addr_decode
    import bct_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          FAST_LEN    = 6,
    parameter int          SLOW_LEN    = 8,
    parameter int          JOY_LEN     = 12,
    parameter int          LEN_W       = 4,
    parameter logic [7:0]  WRAM_BANK_A = 8'h7E,
    parameter logic [7:0]  WRAM_BANK_B = 8'h7F,
    parameter int          LOWRAM_TOP  = 'h2000,
    parameter int          REG_TOP     = 'h6000,
    parameter int          JOY_PORT_A  = 'h4016,
    parameter int          JOY_PORT_B  = 'h4017
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              internal,
    input  logic              fast_en,
    output logic [LEN_W-1:0]  acc_len
);

    localparam int OFF_W = ADDR_W - BANK_W;

    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  off;
    logic              sys_bank;
    acc_class_e        cls;

    assign bank     = addr[ADDR_W-1 -: BANK_W];
    assign off      = addr[OFF_W-1:0];
    // banks with bit 6 clear carry low RAM, registers and joypad ports
    assign sys_bank = ~bank[BANK_W-2];

    always_comb begin
        if (internal) begin
            cls = CLS_INTERNAL;
        end else if (bank == WRAM_BANK_A || bank == WRAM_BANK_B) begin
            cls = CLS_WRAM;
        end else if (sys_bank && off < OFF_W'(LOWRAM_TOP)) begin
            cls = CLS_WRAM;
        end else if (sys_bank && (off == OFF_W'(JOY_PORT_A) || off == OFF_W'(JOY_PORT_B))) begin
            cls = CLS_JOY;
        end else if (sys_bank && off < OFF_W'(REG_TOP)) begin
            cls = CLS_REG;
        end else if (bank[BANK_W-1] && fast_en) begin
            cls = CLS_ROM_FAST;
        end else begin
            cls = CLS_ROM_SLOW;
        end
    end

    always_comb begin
        unique case (cls)
            CLS_INTERNAL,
            CLS_ROM_FAST,
            CLS_REG:       acc_len = LEN_W'(FAST_LEN);
            CLS_JOY:       acc_len = LEN_W'(JOY_LEN);
            default:       acc_len = LEN_W'(SLOW_LEN);
        endcase
    end

endmodule

// File: rtl/bct_fast_reg.sv
module bct_fast_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    output logic fast_en
);

    logic fast_d, fast_q;

    always_comb begin
        fast_d = fast_q;
        if (wr_en) begin
            fast_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else begin
            fast_q <= fast_d;
        end
    end

    assign fast_en = fast_q;

endmodule

// File: rtl/bct_refresh_window.sv
module bct_refresh_window #(
    parameter int REFRESH_LEN = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic stall
);

    localparam int WIN_W = $clog2(REFRESH_LEN + 1);

    logic [WIN_W-1:0] win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (win_q != '0) begin
            win_d = win_q - 1'b1;
        end else if (req) begin
            // request clock is the first stalled clock
            win_d = WIN_W'(REFRESH_LEN - 1);
        end
        stall = req || (win_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

endmodule

// File: rtl/bct_cycle_seq.sv
module bct_cycle_seq #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic [LEN_W-1:0] new_len,
    output logic             start,
    output logic             done,
    output logic [LEN_W-1:0] cur_len
);

    typedef struct packed {
        logic [LEN_W-1:0] pos;
        logic [LEN_W-1:0] len;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = (st_q.pos == '0) && !stall;
        done  = !stall && (st_q.pos != '0) && (st_q.pos == st_q.len - 1'b1);
        if (!stall) begin
            if (st_q.pos == '0) begin
                st_d.len = new_len;
                st_d.pos = LEN_W'(1);
            end else if (done) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_len = st_q.len;

endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
    parameter int ADDR_W      = 24,
    parameter int FAST_LEN    = 6,
    parameter int SLOW_LEN    = 8,
    parameter int JOY_LEN     = 12,
    parameter int REFRESH_LEN = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_internal,
    input  logic                          fast_we,
    input  logic                          fast_wdata,
    input  logic                          refresh_req,
    output logic                          cyc_start,
    output logic                          cyc_done,
    output logic                          bus_stall,
    output logic [$clog2(JOY_LEN+1)-1:0]  cyc_len
);

    localparam int LEN_W = $clog2(JOY_LEN + 1);

    logic             fast_en;
    logic [LEN_W-1:0] acc_len;

    bct_fast_reg u_fast (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fast_we),
        .wr_data (fast_wdata),
        .fast_en (fast_en)
    );

    bct_addr_decode #(
        .ADDR_W   (ADDR_W),
        .FAST_LEN (FAST_LEN),
        .SLOW_LEN (SLOW_LEN),
        .JOY_LEN  (JOY_LEN),
        .LEN_W    (LEN_W)
    ) u_dec (
        .addr     (bus_addr),
        .internal (bus_internal),
        .fast_en  (fast_en),
        .acc_len  (acc_len)
    );

    bct_refresh_window #(
        .REFRESH_LEN (REFRESH_LEN)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (refresh_req),
        .stall (bus_stall)
    );

    bct_cycle_seq #(
        .LEN_W (LEN_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (bus_stall),
        .new_len (acc_len),
        .start   (cyc_start),
        .done    (cyc_done),
        .cur_len (cyc_len)
    );

endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
    parameter int FAST_LEN = 6,
    parameter int SLOW_LEN = 8,
    parameter int JOY_LEN  = 12,
    parameter int LEN_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_internal,
    input logic             refresh_req,
    input logic             cyc_start,
    input logic             cyc_done,
    input logic             bus_stall,
    input logic [LEN_W-1:0] cyc_len
);

    AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> bus_stall); // R10

    AST_QUIET_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stall |-> (!cyc_done && !cyc_start)); // R10

    AST_LEN_HELD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stall |=> $stable(cyc_len)); // R10

    AST_DONE_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (cyc_start || bus_stall)); // R8

    AST_START_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_start && cyc_done)); // R8

    AST_MID_CYCLE_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && !cyc_done) |=> $stable(cyc_len)); // R8

    AST_DONE_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> (cyc_len == LEN_W'(FAST_LEN) || cyc_len == LEN_W'(SLOW_LEN)
                      || cyc_len == LEN_W'(JOY_LEN))); // R12

    AST_INTERNAL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && bus_internal) |=> cyc_len == LEN_W'(FAST_LEN)); // R7

endmodule

bind bus_cycle_timer bct_checker #(
    .FAST_LEN (FAST_LEN),
    .SLOW_LEN (SLOW_LEN),
    .JOY_LEN  (JOY_LEN),
    .LEN_W    (LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_internal (bus_internal),
    .refresh_req  (refresh_req),
    .cyc_start    (cyc_start),
    .cyc_done     (cyc_done),
    .bus_stall    (bus_stall),
    .cyc_len      (cyc_len)
);

// File: tb/bus_cycle_timer_test.sv
`timescale 1ns/1ps
module bus_cycle_timer_test;

    localparam int REFRESH_LEN = 40;

    typedef struct {
        int    len;
        string tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_internal = 1'b0;
    logic        fast_we = 1'b0;
    logic        fast_wdata = 1'b0;
    logic        refresh_req = 1'b0;
    logic        cyc_start, cyc_done, bus_stall;
    logic [3:0]  cyc_len;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          run_cnt = 0;
    int          stall_run = 0;
    bit          m_fast = 1'b0;
    string       stall_tag = "R10";
    exp_item_t   exp_q[$];

    always #2.5 clk = ~clk;

    bus_cycle_timer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_internal (bus_internal),
        .fast_we      (fast_we),
        .fast_wdata   (fast_wdata),
        .refresh_req  (refresh_req),
        .cyc_start    (cyc_start),
        .cyc_done     (cyc_done),
        .bus_stall    (bus_stall),
        .cyc_len      (cyc_len)
    );

    function automatic int ref_len(logic [23:0] a, bit internal, bit fast);
        logic [7:0]  b = a[23:16];
        logic [15:0] o = a[15:0];
        if (internal) return 6;
        if (b == 8'h7E || b == 8'h7F) return 8;
        if (!b[6]) begin
            if (o < 16'h2000) return 8;
            if (o == 16'h4016 || o == 16'h4017) return 12;
            if (o < 16'h6000) return 6;
        end
        if (b[7] && fast) return 6;
        return 8;
    endfunction

    function automatic string tag_of(logic [23:0] a, bit internal, bit fast);
        logic [7:0]  b = a[23:16];
        logic [15:0] o = a[15:0];
        if (internal) return "R7";
        if (b == 8'h7E || b == 8'h7F) return "R4";
        if (!b[6] && o < 16'h2000) return "R4";
        if (!b[6] && (o == 16'h4016 || o == 16'h4017)) return "R6";
        if (!b[6] && o < 16'h6000) return "R5";
        if (b[7] && fast) return "R2";
        return "R3";
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: measure non-stalled clocks per cycle and stall window lengths
    always @(negedge clk) begin
        exp_item_t it;
        if (rst_n) begin
            if (bus_stall) begin
                stall_run++;
            end else begin
                if (stall_run != 0) begin
                    check(stall_run == REFRESH_LEN, stall_tag, stall_run, REFRESH_LEN);
                    stall_run = 0;
                end
                run_cnt++;
            end
            if (cyc_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(run_cnt == it.len, it.tag, run_cnt, it.len);
                    check(int'(cyc_len) == it.len, "R12", int'(cyc_len), it.len);
                end
                run_cnt = 0;
            end
        end
    end

    // driver: called just after the edge that begins a start clock
    task automatic run_cycle(input logic [23:0] a, input bit internal, input string tag,
                             input int req_at, input bit dbl_req,
                             input bit do_wr, input bit wr_val, input bit scramble);
        exp_item_t it;
        int k;
        bus_addr     = a;
        bus_internal = internal;
        it.len = ref_len(a, internal, m_fast);
        it.tag = (tag == "") ? tag_of(a, internal, m_fast) : tag;
        exp_q.push_back(it);
        if (do_wr) begin
            fast_we    = 1'b1;
            fast_wdata = wr_val;
        end
        @(posedge clk) #1;
        fast_we = 1'b0;
        if (do_wr) m_fast = wr_val;
        if (scramble) begin
            // R8: late changes must not alter the sampled length
            bus_addr     = 24'h004016;
            bus_internal = ref_len(24'h004016, 1'b0, m_fast) == it.len;
        end
        k = 0;
        forever begin
            if (req_at >= 0 && k == req_at) refresh_req = 1'b1;
            else if (dbl_req && k == req_at + 5) refresh_req = 1'b1;  // R11
            else refresh_req = 1'b0;
            @(negedge clk);
            if (cyc_done) break;
            @(posedge clk) #1;
            k++;
        end
        @(posedge clk) #1;
        refresh_req = 1'b0;
    endtask

    initial begin
        #1000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_item_t it;
        repeat (3) @(posedge clk);
        #1;
        bus_addr = 24'h000000;
        it.len = 8;
        it.tag = "R1";
        exp_q.push_back(it);
        rst_n = 1'b1;
        @(negedge clk);
        check(cyc_start == 1'b1, "R1 start", int'(cyc_start), 1);
        check(cyc_done == 1'b0, "R1 done", int'(cyc_done), 0);
        check(bus_stall == 1'b0, "R1 stall", int'(bus_stall), 0);
        while (!cyc_done) @(negedge clk);
        @(posedge clk) #1;

        // fast bit resets to 0: high-bank ROM is slow (R1, R9)
        run_cycle(24'h808000, 0, "R9", -1, 0, 0, 0, 0);
        run_cycle(24'h008000, 0, "R3", -1, 0, 0, 0, 0);
        run_cycle(24'h408000, 0, "R3", -1, 0, 0, 0, 0);
        run_cycle(24'h7E1234, 0, "R4", -1, 0, 0, 0, 0);
        run_cycle(24'h7FFFFF, 0, "R4", -1, 0, 0, 0, 0);
        run_cycle(24'h001FFF, 0, "R4", -1, 0, 0, 0, 0);
        run_cycle(24'h801FFF, 0, "R4", -1, 0, 0, 0, 0);
        run_cycle(24'h002000, 0, "R5", -1, 0, 0, 0, 0);
        run_cycle(24'h005FFF, 0, "R5", -1, 0, 0, 0, 0);
        run_cycle(24'h004015, 0, "R5", -1, 0, 0, 0, 0);
        run_cycle(24'h004016, 0, "R6", -1, 0, 0, 0, 0);
        run_cycle(24'h804017, 0, "R6", -1, 0, 0, 0, 0);
        run_cycle(24'h3F4017, 0, "R6", -1, 0, 0, 0, 0);
        run_cycle(24'h404016, 0, "R3", -1, 0, 0, 0, 0);
        run_cycle(24'h004016, 1, "R7", -1, 0, 0, 0, 0);
        // write in a start clock: this cycle keeps the old bit (R9)
        run_cycle(24'h808000, 0, "R9", -1, 0, 1, 1, 0);
        run_cycle(24'h808000, 0, "R2", -1, 0, 0, 0, 0);
        run_cycle(24'hC00000, 0, "R2", -1, 0, 0, 0, 0);
        run_cycle(24'hFFFFFF, 0, "R2", -1, 0, 0, 0, 0);
        run_cycle(24'h806000, 0, "R2", -1, 0, 0, 0, 0);
        run_cycle(24'h408000, 0, "R3", -1, 0, 0, 0, 0);
        run_cycle(24'h802100, 0, "R5", -1, 0, 0, 0, 0);
        run_cycle(24'h7E0000, 0, "R8", -1, 0, 0, 0, 1);
        run_cycle(24'h008000, 0, "R8", -1, 0, 0, 0, 1);
        stall_tag = "R10";
        run_cycle(24'h004016, 0, "R10", 3, 0, 0, 0, 0);
        stall_tag = "R11";
        run_cycle(24'h7E0010, 0, "R11", 2, 1, 0, 0, 0);
        stall_tag = "R10";
        run_cycle(24'h808000, 0, "R9", -1, 0, 1, 0, 0);
        run_cycle(24'hC00000, 0, "R9", -1, 0, 0, 0, 0);

        for (int i = 0; i < 300; i++) begin
            logic [23:0] a;
            bit          intl;
            bit          wr;
            int          rq;
            a    = 24'($urandom);
            case ($urandom % 4)
                0: a[15:0] = 16'h4016 + 16'($urandom % 2);
                1: a[15:0] = 16'h2000 + 16'($urandom % 16'h4000);
                default: ;
            endcase
            if ($urandom % 3 == 0) a[22] = 1'b0;
            intl = ($urandom % 8) == 0;
            wr   = ($urandom % 6) == 0;
            rq   = (($urandom % 10) == 0) ? int'($urandom % 4) : -1;
            run_cycle(a, intl, "", rq, 0, wr, 1'($urandom), ($urandom % 5) == 0);
        end

        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R8 pending", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule